// File: doc/BRIEF.md
# Wide Bus Odd-Byte Residual Handler

This block joins a byte-wide memory data stream to a 16-bit peripheral data bus. Each move is started by a command that gives a direction, a move type (normal or chained) and a byte count. In the send direction, memory bytes are packed two to a bus word, with the first byte in the low lane. In the receive direction, each bus word is split back into its low byte and then its high byte.

When a byte count is odd, one byte is left over. A chained send keeps its trailing low byte instead of putting it on the bus. The next send move of either type places its first byte in the high lane next to the kept byte, and the two leave as one word. A receive move that ends on an odd count keeps the unused high byte of its last bus word, whatever the move type. The next receive move hands that byte to memory before it takes any bus data.

Two pending flags and a 16-bit residue register are visible at the ports. Software can clear either flag while no move is running, and the clear also throws away the kept byte.

Top module: `wbr_top`

## Requirements
- R1: After reset, send_flag, recv_flag and hold_word are 0, cmd_ready is 1, and bus_out_valid and mem_out_valid are 0.
- R2: A send move with no pending residue packs bytes in pairs, with the earlier byte in bits [7:0] and the later byte in bits [15:8]. The word is presented on the bus in the same cycle as its second byte, with bus_out_half at 0. The first byte of a pair is accepted without any bus output.
- R3: A normal send move with an odd count puts its last byte on the bus as a half word: data {8'h00, byte}, bus_out_half at 1. send_flag stays 0.
- R4: A chained send move with an odd count accepts its last byte without driving the bus. The byte is stored in hold_word[7:0], and send_flag reads 1 from the next cycle.
- R5: When a send move starts with send_flag set, normal or chained, its first byte goes out in bits [15:8] and hold_word[7:0] goes out in bits [7:0] of one full word. send_flag reads 0 in the cycle after that word is accepted.
- R6: A receive move hands each bus word to memory as two bytes, the low byte first and then the high byte. bus_in_ready is asserted only together with the last byte taken from that word.
- R7: A receive move of either type that ends on an odd count passes the low byte of its last bus word to memory and accepts that word. The high byte is stored in hold_word[15:8], and recv_flag reads 1 from the next cycle.
- R8: When a receive move starts with recv_flag set, recv_flag reads 0 from the cycle after the command is accepted. The kept byte is the first byte handed to memory, it counts toward the byte count, and bus_in_ready stays 0 while it is offered.
- R9: A pulse on sw_clr_send or sw_clr_recv while cmd_ready is 1 clears that flag and zeroes its byte in hold_word from the next cycle. The next move of that direction then behaves as if there were no residue. Clear pulses while a move is running are ignored.
- R10: A command is taken only when cmd_valid and cmd_ready are both 1 and cmd_count is nonzero (cmd_dir 0 = send, 1 = receive). cmd_ready is 0 while a move runs, and a command with count 0 leaves cmd_ready at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Move command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_dir | input | 1 | 0 = send (memory to bus), 1 = receive |
| cmd_chain | input | 1 | 1 = chained move, 0 = normal move |
| cmd_count | input | 16 | Byte count of the move |
| mem_in_valid | input | 1 | Memory byte offered for sending |
| mem_in_ready | output | 1 | Memory byte taken |
| mem_in_data | input | 8 | Memory byte to send |
| mem_out_valid | output | 1 | Received byte offered to memory |
| mem_out_ready | input | 1 | Memory takes the byte |
| mem_out_data | output | 8 | Received byte |
| bus_out_valid | output | 1 | Bus word offered |
| bus_out_ready | input | 1 | Bus takes the word |
| bus_out_data | output | 16 | Bus word being sent |
| bus_out_half | output | 1 | Only the low lane of bus_out_data is meaningful |
| bus_in_valid | input | 1 | Bus word offered for receiving |
| bus_in_ready | output | 1 | Bus word consumed |
| bus_in_data | input | 16 | Received bus word |
| sw_clr_send | input | 1 | Software clear of the send residue |
| sw_clr_recv | input | 1 | Software clear of the receive residue |
| send_flag | output | 1 | Send residue pending |
| recv_flag | output | 1 | Receive residue pending |
| hold_word | output | 16 | Residue register: [7:0] send byte, [15:8] receive byte |

## Verification
The data-path results have no registers in the way. A packed bus word, a half word, a byte passed to memory and the ready toward the producer all follow the inputs within the same cycle. The bench therefore drives each byte or word just after a falling edge and samples one nanosecond later, before the edge that completes the handshake. The flags and hold_word are registered. A residue set, a clear after a combined word, a clear at a receive start or a software clear becomes visible one edge after its cause, so those are sampled at the next falling edge. An accepted command makes cmd_ready fall at the following edge.

// File: rtl/wbr_pkg.sv
// Package: shared state encodings for the odd-byte residual handler.
// Assumes byte lanes are LANE_W bits wide and the bus carries two lanes.
package wbr_pkg;

    typedef enum logic [1:0] {
        SND_IDLE,
        SND_PAIR,   // first byte joins the pending low byte
        SND_LO,     // waiting for the low byte of a word
        SND_HI      // low byte held, waiting for the high byte
    } snd_state_e;

    typedef enum logic [1:0] {
        RCV_IDLE,
        RCV_RES,    // hand the kept byte to memory first
        RCV_LO,     // low byte of the current bus word
        RCV_HI      // high byte of the current bus word
    } rcv_state_e;

    localparam logic DIR_SEND = 1'b0;
    localparam logic DIR_RECV = 1'b1;

endpackage

// File: rtl/wbr_send_lane.sv
// Send lane: packs memory bytes into two-lane bus words.
// The output is combinational from the second byte of a pair, so a word
// leaves in the cycle its high byte arrives. At the start of a move a pending
// residue is joined with the first byte. A chained move keeps its odd tail
// byte and a normal move sends it as a half word.
// Assumes start is only pulsed while idle with a nonzero count, and that
// res_byte stays stable for the whole move.
module wbr_send_lane
    import wbr_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                chain,
    input  logic [CNT_W-1:0]    count,
    input  logic                res_valid,
    input  logic [LANE_W-1:0]   res_byte,
    input  logic                mem_in_valid,
    input  logic [LANE_W-1:0]   mem_in_data,
    output logic                mem_in_ready,
    output logic                bus_out_valid,
    input  logic                bus_out_ready,
    output logic [2*LANE_W-1:0] bus_out_data,
    output logic                bus_out_half,
    output logic                busy,
    output logic                res_set,
    output logic                res_used
);

    snd_state_e          state;
    logic [CNT_W-1:0]    rem;
    logic                chain_q;
    logic [LANE_W-1:0]   lo_q;
    logic                last;
    logic                take;

    assign last = (rem == CNT_W'(1));
    assign take = mem_in_valid && mem_in_ready;
    assign busy = (state != SND_IDLE);

    // Steer the byte lanes and handshakes for the current state.
    always_comb begin
        mem_in_ready  = 1'b0;
        bus_out_valid = 1'b0;
        bus_out_data  = '0;
        bus_out_half  = 1'b0;
        res_set       = 1'b0;
        res_used      = 1'b0;
        case (state)
            SND_PAIR: begin
                bus_out_valid = mem_in_valid;
                bus_out_data  = {mem_in_data, res_byte};
                mem_in_ready  = bus_out_ready;
                res_used      = mem_in_valid && bus_out_ready;
            end
            SND_LO: begin
                if (last && !chain_q) begin
                    bus_out_valid = mem_in_valid;
                    bus_out_data  = {{LANE_W{1'b0}}, mem_in_data};
                    bus_out_half  = 1'b1;
                    mem_in_ready  = bus_out_ready;
                end else begin
                    mem_in_ready  = 1'b1;
                    res_set       = last && chain_q && mem_in_valid;
                end
            end
            SND_HI: begin
                bus_out_valid = mem_in_valid;
                bus_out_data  = {mem_in_data, lo_q};
                mem_in_ready  = bus_out_ready;
            end
            default: ;
        endcase
    end

    // Advance the byte counter and the pairing state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SND_IDLE;
            rem     <= '0;
            chain_q <= 1'b0;
            lo_q    <= '0;
        end else begin
            case (state)
                SND_IDLE: begin
                    if (start) begin
                        rem     <= count;
                        chain_q <= chain;
                        state   <= res_valid ? SND_PAIR : SND_LO;
                    end
                end
                default: begin
                    if (take) begin
                        rem <= rem - CNT_W'(1);
                        if (state == SND_LO) lo_q <= mem_in_data;
                        if (last)                  state <= SND_IDLE;
                        else if (state == SND_LO)  state <= SND_HI;
                        else                       state <= SND_LO;
                    end
                end
            endcase
        end
    end

    AST_SND_REM_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> rem != '0); // R10
    AST_SND_HALF_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_out_valid && bus_out_half |-> !chain_q); // R3
    AST_SND_TAIL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        res_set |=> !busy); // R4
    AST_SND_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_out_valid && !bus_out_ready |-> !mem_in_ready); // R2

endmodule

// File: rtl/wbr_recv_lane.sv
// Receive lane: splits two-lane bus words into bytes for memory, low lane
// first. A pending residue byte is handed over before any bus data. When the
// count runs out on a low byte, the word is accepted and its high byte is
// handed to the residue register.
// Assumes start is only pulsed while idle with a nonzero count, and that
// bus_in_data stays stable while bus_in_valid is held.
module wbr_recv_lane
    import wbr_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [CNT_W-1:0]    count,
    input  logic                res_valid,
    input  logic [LANE_W-1:0]   res_byte,
    input  logic                bus_in_valid,
    input  logic [2*LANE_W-1:0] bus_in_data,
    output logic                bus_in_ready,
    output logic                mem_out_valid,
    input  logic                mem_out_ready,
    output logic [LANE_W-1:0]   mem_out_data,
    output logic                busy,
    output logic                res_set
);

    rcv_state_e          state;
    logic [CNT_W-1:0]    rem;
    logic                last;
    logic                take;

    assign last = (rem == CNT_W'(1));
    assign take = mem_out_valid && mem_out_ready;
    assign busy = (state != RCV_IDLE);

    // Pick the byte offered to memory and decide when the bus word is consumed.
    always_comb begin
        mem_out_valid = 1'b0;
        mem_out_data  = '0;
        bus_in_ready  = 1'b0;
        res_set       = 1'b0;
        case (state)
            RCV_RES: begin
                mem_out_valid = 1'b1;
                mem_out_data  = res_byte;
            end
            RCV_LO: begin
                mem_out_valid = bus_in_valid;
                mem_out_data  = bus_in_data[LANE_W-1:0];
                bus_in_ready  = last && mem_out_ready;
                res_set       = last && bus_in_valid && mem_out_ready;
            end
            RCV_HI: begin
                mem_out_valid = bus_in_valid;
                mem_out_data  = bus_in_data[2*LANE_W-1:LANE_W];
                bus_in_ready  = mem_out_ready;
            end
            default: ;
        endcase
    end

    // Advance the byte counter and the lane selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RCV_IDLE;
            rem   <= '0;
        end else begin
            case (state)
                RCV_IDLE: begin
                    if (start) begin
                        rem   <= count;
                        state <= res_valid ? RCV_RES : RCV_LO;
                    end
                end
                default: begin
                    if (take) begin
                        rem <= rem - CNT_W'(1);
                        if (last)                  state <= RCV_IDLE;
                        else if (state == RCV_LO)  state <= RCV_HI;
                        else                       state <= RCV_LO;
                    end
                end
            endcase
        end
    end

    AST_RCV_REM_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> rem != '0); // R10
    AST_RCV_RES_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        state == RCV_RES |-> !bus_in_ready); // R8
    AST_RCV_WORD_WITH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_in_valid && bus_in_ready |-> mem_out_valid && mem_out_ready); // R6
    AST_RCV_TAIL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        res_set |=> !busy); // R7

endmodule

// File: rtl/wbr_residue_regs.sv
// Residue register file: the two pending flags and the held bytes.
// Low half holds the send residue, high half holds the receive residue.
// A set in the same cycle as a clear wins. Clears are pre-gated by the top.
module wbr_residue_regs #(
    parameter int LANE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                snd_set,
    input  logic [LANE_W-1:0]   snd_byte,
    input  logic                snd_used,
    input  logic                clr_snd,
    input  logic                rcv_start,
    input  logic                rcv_set,
    input  logic [LANE_W-1:0]   rcv_byte,
    input  logic                clr_rcv,
    output logic                send_flag,
    output logic                recv_flag,
    output logic [2*LANE_W-1:0] hold_word
);

    // Update the send residue: latch on a chained tail, drop on use or clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            send_flag                <= 1'b0;
            hold_word[LANE_W-1:0]    <= '0;
        end else if (snd_set) begin
            send_flag                <= 1'b1;
            hold_word[LANE_W-1:0]    <= snd_byte;
        end else if (clr_snd) begin
            send_flag                <= 1'b0;
            hold_word[LANE_W-1:0]    <= '0;
        end else if (snd_used) begin
            send_flag                <= 1'b0;
        end
    end

    // Update the receive residue: latch on a partial end, drop at the next start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            recv_flag                  <= 1'b0;
            hold_word[2*LANE_W-1:LANE_W] <= '0;
        end else if (rcv_set) begin
            recv_flag                  <= 1'b1;
            hold_word[2*LANE_W-1:LANE_W] <= rcv_byte;
        end else if (clr_rcv) begin
            recv_flag                  <= 1'b0;
            hold_word[2*LANE_W-1:LANE_W] <= '0;
        end else if (rcv_start) begin
            recv_flag                  <= 1'b0;
        end
    end

    AST_SND_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        snd_set |=> send_flag && hold_word[LANE_W-1:0] == $past(snd_byte)); // R4
    AST_SND_USED_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        snd_used && !snd_set |=> !send_flag); // R5
    AST_RCV_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rcv_start && !rcv_set |=> !recv_flag); // R8
    AST_RCV_CLR_DISCARDS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_rcv && !rcv_set |=> hold_word[2*LANE_W-1:LANE_W] == '0); // R9

endmodule

// File: rtl/wbr_top.sv
// Top: odd-byte residual handler between a byte memory path and a two-lane
// bus. It accepts move commands while both lanes are idle, routes them by
// direction, and gates software clears to idle periods.
// Assumes the memory and bus sides follow valid/ready rules.
module wbr_top
    import wbr_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int CNT_W  = 16,
    localparam int BUS_W = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_dir,
    input  logic              cmd_chain,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic              mem_in_valid,
    output logic              mem_in_ready,
    input  logic [LANE_W-1:0] mem_in_data,
    output logic              mem_out_valid,
    input  logic              mem_out_ready,
    output logic [LANE_W-1:0] mem_out_data,
    output logic              bus_out_valid,
    input  logic              bus_out_ready,
    output logic [BUS_W-1:0]  bus_out_data,
    output logic              bus_out_half,
    input  logic              bus_in_valid,
    output logic              bus_in_ready,
    input  logic [BUS_W-1:0]  bus_in_data,
    input  logic              sw_clr_send,
    input  logic              sw_clr_recv,
    output logic              send_flag,
    output logic              recv_flag,
    output logic [BUS_W-1:0]  hold_word
);

    logic snd_busy, rcv_busy;
    logic snd_start, rcv_start;
    logic snd_set, snd_used, rcv_set;
    logic accept;

    // Take a command only while idle and only with a nonzero count.
    assign cmd_ready = !snd_busy && !rcv_busy;
    assign accept    = cmd_valid && cmd_ready && (cmd_count != '0);
    assign snd_start = accept && (cmd_dir == DIR_SEND);
    assign rcv_start = accept && (cmd_dir == DIR_RECV);

    wbr_send_lane #(.LANE_W(LANE_W), .CNT_W(CNT_W)) u_send (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (snd_start),
        .chain         (cmd_chain),
        .count         (cmd_count),
        .res_valid     (send_flag),
        .res_byte      (hold_word[LANE_W-1:0]),
        .mem_in_valid  (mem_in_valid),
        .mem_in_data   (mem_in_data),
        .mem_in_ready  (mem_in_ready),
        .bus_out_valid (bus_out_valid),
        .bus_out_ready (bus_out_ready),
        .bus_out_data  (bus_out_data),
        .bus_out_half  (bus_out_half),
        .busy          (snd_busy),
        .res_set       (snd_set),
        .res_used      (snd_used)
    );

    wbr_recv_lane #(.LANE_W(LANE_W), .CNT_W(CNT_W)) u_recv (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (rcv_start),
        .count         (cmd_count),
        .res_valid     (recv_flag),
        .res_byte      (hold_word[BUS_W-1:LANE_W]),
        .bus_in_valid  (bus_in_valid),
        .bus_in_data   (bus_in_data),
        .bus_in_ready  (bus_in_ready),
        .mem_out_valid (mem_out_valid),
        .mem_out_ready (mem_out_ready),
        .mem_out_data  (mem_out_data),
        .busy          (rcv_busy),
        .res_set       (rcv_set)
    );

    wbr_residue_regs #(.LANE_W(LANE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .snd_set   (snd_set),
        .snd_byte  (mem_in_data),
        .snd_used  (snd_used),
        .clr_snd   (sw_clr_send && cmd_ready),
        .rcv_start (rcv_start),
        .rcv_set   (rcv_set),
        .rcv_byte  (bus_in_data[BUS_W-1:LANE_W]),
        .clr_rcv   (sw_clr_recv && cmd_ready),
        .send_flag (send_flag),
        .recv_flag (recv_flag),
        .hold_word (hold_word)
    );

    AST_LANES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(snd_busy && rcv_busy)); // R10
    AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !cmd_ready); // R10
    AST_BUSY_CLEAR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clr_send && !cmd_ready && send_flag && !snd_used |=> send_flag); // R9

endmodule

// File: tb/tb_wbr_top.sv
module tb_wbr_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid, cmd_ready, cmd_dir, cmd_chain;
    logic [15:0] cmd_count;
    logic        mem_in_valid, mem_in_ready;
    logic [7:0]  mem_in_data;
    logic        mem_out_valid, mem_out_ready;
    logic [7:0]  mem_out_data;
    logic        bus_out_valid, bus_out_ready, bus_out_half;
    logic [15:0] bus_out_data;
    logic        bus_in_valid, bus_in_ready;
    logic [15:0] bus_in_data;
    logic        sw_clr_send, sw_clr_recv;
    logic        send_flag, recv_flag;
    logic [15:0] hold_word;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // bench model of the pending residues
    bit         m_sres = 0;
    logic [7:0] m_slo  = '0;
    bit         m_rres = 0;
    logic [7:0] m_rhi  = '0;

    always #10 clk = ~clk;

    wbr_top dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_dir(cmd_dir),
        .cmd_chain(cmd_chain), .cmd_count(cmd_count),
        .mem_in_valid(mem_in_valid), .mem_in_ready(mem_in_ready), .mem_in_data(mem_in_data),
        .mem_out_valid(mem_out_valid), .mem_out_ready(mem_out_ready), .mem_out_data(mem_out_data),
        .bus_out_valid(bus_out_valid), .bus_out_ready(bus_out_ready),
        .bus_out_data(bus_out_data), .bus_out_half(bus_out_half),
        .bus_in_valid(bus_in_valid), .bus_in_ready(bus_in_ready), .bus_in_data(bus_in_data),
        .sw_clr_send(sw_clr_send), .sw_clr_recv(sw_clr_recv),
        .send_flag(send_flag), .recv_flag(recv_flag), .hold_word(hold_word)
    );

    // vector: dir[26] chain[25] count[24:9] seed[8:1] flag_after[0]
    localparam logic [26:0] VECS [12] = '{
        {1'b0, 1'b0, 16'd4, 8'h10, 1'b0},   // R2 even send
        {1'b0, 1'b0, 16'd3, 8'h20, 1'b0},   // R3 odd normal send
        {1'b0, 1'b1, 16'd5, 8'h30, 1'b1},   // R4 odd chained send
        {1'b0, 1'b0, 16'd2, 8'h40, 1'b0},   // R5 pair then half word
        {1'b0, 1'b1, 16'd3, 8'h50, 1'b1},   // R4
        {1'b0, 1'b1, 16'd1, 8'h60, 1'b0},   // R5 pair only
        {1'b1, 1'b0, 16'd4, 8'h70, 1'b0},   // R6 even receive
        {1'b1, 1'b0, 16'd3, 8'h80, 1'b1},   // R7 odd normal receive
        {1'b1, 1'b1, 16'd4, 8'h90, 1'b1},   // R8 residue first, R7 again
        {1'b1, 1'b1, 16'd1, 8'hA0, 1'b0},   // R8 residue only
        {1'b1, 1'b1, 16'd5, 8'hB0, 1'b1},   // R7 chained receive
        {1'b0, 1'b1, 16'd2, 8'hC0, 1'b0}    // R2 even chained send
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after acceptance
    task automatic issue_cmd(input logic dir, input logic chain, input logic [15:0] cnt);
        cmd_valid = 1'b1; cmd_dir = dir; cmd_chain = chain; cmd_count = cnt;
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_bytes(input logic chain, input int cnt, input logic [7:0] seed);
        logic [7:0] b, lo;
        bit have_lo = 0;
        lo = '0;
        for (int i = 0; i < cnt; i++) begin
            b = 8'(seed + i);
            mem_in_valid = 1'b1; mem_in_data = b;
            #1;
            // observed: {ready, valid, half, data-when-valid}
            if (m_sres) begin
                check("R5 joined word", {mem_in_ready, bus_out_valid, bus_out_half,
                      bus_out_valid ? bus_out_data : 16'h0}, {3'b110, b, m_slo});
                m_sres = 0;
            end else if (!have_lo && i == cnt - 1) begin
                if (chain) begin
                    check("R4 tail kept off bus", {mem_in_ready, bus_out_valid}, 2'b10);
                    m_sres = 1; m_slo = b;
                end else begin
                    check("R3 half word", {mem_in_ready, bus_out_valid, bus_out_half,
                          bus_out_valid ? bus_out_data : 16'h0}, {3'b111, 8'h00, b});
                end
            end else if (!have_lo) begin
                check("R2 low byte taken", {mem_in_ready, bus_out_valid}, 2'b10);
                lo = b; have_lo = 1;
            end else begin
                check("R2 packed word", {mem_in_ready, bus_out_valid, bus_out_half,
                      bus_out_valid ? bus_out_data : 16'h0}, {3'b110, b, lo});
                have_lo = 0;
            end
            @(posedge clk); @(negedge clk);
        end
        mem_in_valid = 1'b0;
        #1;
        check("R4 R5 send_flag after move", send_flag, m_sres);
        if (m_sres) check("R4 held low byte", hold_word[7:0], m_slo);
    endtask

    task automatic run_recv(input logic chain, input int cnt, input logic [7:0] seed);
        logic [15:0] w;
        int i = 0;
        int k = 0;
        issue_cmd(1'b1, chain, 16'(cnt));
        #1;
        check("R8 recv_flag cleared at start", recv_flag, 1'b0);
        if (m_rres) begin
            bus_in_valid = 1'b0;
            #1;
            check("R8 kept byte first", {mem_out_valid, bus_in_ready, mem_out_data},
                  {2'b10, m_rhi});
            @(posedge clk); @(negedge clk);
            m_rres = 0; i = 1;
        end
        while (i < cnt) begin
            w = {8'(seed + 2*k + 1), 8'(seed + 2*k)};
            bus_in_valid = 1'b1; bus_in_data = w;
            #1;
            if (i == cnt - 1) begin
                check("R7 last low byte, word taken", {mem_out_valid, bus_in_ready, mem_out_data},
                      {2'b11, w[7:0]});
                @(posedge clk); @(negedge clk);
                m_rres = 1; m_rhi = w[15:8]; i++;
            end else begin
                check("R6 low byte first", {mem_out_valid, bus_in_ready, mem_out_data},
                      {2'b10, w[7:0]});
                @(posedge clk); @(negedge clk);
                #1;
                check("R6 high byte, word taken", {mem_out_valid, bus_in_ready, mem_out_data},
                      {2'b11, w[15:8]});
                @(posedge clk); @(negedge clk);
                i += 2;
            end
            k++;
        end
        bus_in_valid = 1'b0;
        #1;
        check("R7 recv_flag after move", recv_flag, m_rres);
        if (m_rres) check("R7 held high byte", hold_word[15:8], m_rhi);
    endtask

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        cmd_valid = 0; cmd_dir = 0; cmd_chain = 0; cmd_count = '0;
        mem_in_valid = 0; mem_in_data = '0; mem_out_ready = 1'b1;
        bus_out_ready = 1'b1; bus_in_valid = 0; bus_in_data = '0;
        sw_clr_send = 0; sw_clr_recv = 0;
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset state", {cmd_ready, send_flag, recv_flag, bus_out_valid,
              mem_out_valid, hold_word}, {5'b10000, 16'h0});
        rst_n = 1'b1;
        @(negedge clk);

        // table walk
        for (int v = 0; v < 12; v++) begin
            if (VECS[v][26] == 1'b0) begin
                issue_cmd(1'b0, VECS[v][25], VECS[v][24:9]);
                send_bytes(VECS[v][25], int'(VECS[v][24:9]), VECS[v][8:1]);
                check("R4 R5 table send_flag", send_flag, VECS[v][0]);
            end else begin
                run_recv(VECS[v][25], int'(VECS[v][24:9]), VECS[v][8:1]);
                check("R7 R8 table recv_flag", recv_flag, VECS[v][0]);
            end
        end

        // R9: software clear of the receive residue while idle
        sw_clr_recv = 1'b1;
        @(posedge clk); @(negedge clk);
        sw_clr_recv = 1'b0;
        #1;
        check("R9 recv clear drops flag and byte", {recv_flag, hold_word[15:8]}, 9'h0);
        m_rres = 0;
        run_recv(1'b0, 2, 8'hD0);   // R9 no residue emitted first

        // R9 and R10: clear and command ignored while a move runs
        issue_cmd(1'b0, 1'b1, 16'd3);
        send_bytes(1'b1, 3, 8'hE0);
        issue_cmd(1'b0, 1'b0, 16'd2);
        sw_clr_send = 1'b1; cmd_valid = 1'b1; cmd_dir = 1'b1; cmd_count = 16'd4;
        #1;
        check("R10 cmd_ready low while busy", cmd_ready, 1'b0);
        @(posedge clk); @(negedge clk);
        sw_clr_send = 1'b0; cmd_valid = 1'b0;
        #1;
        check("R9 busy clear ignored", {send_flag, hold_word[7:0]}, {1'b1, 8'hE2});
        send_bytes(1'b0, 2, 8'hF0);
        check("R10 idle after move", cmd_ready, 1'b1);

        // R10: zero count is not taken
        cmd_valid = 1'b1; cmd_dir = 1'b0; cmd_chain = 1'b1; cmd_count = 16'd0;
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
        #1;
        check("R10 zero count ignored", {cmd_ready, send_flag}, 2'b10);

        // R9: software clear of the send residue while idle
        issue_cmd(1'b0, 1'b1, 16'd1);
        send_bytes(1'b1, 1, 8'h5A);
        sw_clr_send = 1'b1;
        @(posedge clk); @(negedge clk);
        sw_clr_send = 1'b0;
        #1;
        check("R9 send clear drops flag and byte", {send_flag, hold_word[7:0]}, 9'h0);
        m_sres = 0;
        issue_cmd(1'b0, 1'b0, 16'd2);
        send_bytes(1'b0, 2, 8'h11);   // R9 plain pairing afterwards

        // R1: reset clears a pending residue
        issue_cmd(1'b0, 1'b1, 16'd1);
        send_bytes(1'b1, 1, 8'h77);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        #1;
        check("R1 reset clears residue", {cmd_ready, send_flag, recv_flag, hold_word},
              {3'b100, 16'h0});
        rst_n = 1'b1;
        m_sres = 0;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule